// File: doc/BRIEF.md
# E1 National-Bit Data Link Inserter

This block sits in the transmit path of an E1 framer, on the serial bit stream just before line coding. It decides, bit by bit, where each of the five national bits (Sa4 to Sa8) in timeslot 0 of the non-alignment frames takes its value. Each Sa position can be kept from the serial payload stream. It can also be marked as a data link carrier and then filled from one of two places: a bit-oriented link controller, or an overhead input port.

The stream advances one bit per clock cycle. The frame alignment generator pulses `frameStart` on the first bit of every 256-bit frame. On that same cycle it states with `nfasFrame` whether the frame is a non-alignment frame. A 2-bit source code and a 5-bit carrier mask are captured at that frame boundary, so one frame is always built with a single configuration. For link-sourced slots the block raises a request strobe in the slot itself and passes the controller's data bit straight through. For overhead-sourced slots it pulses an overhead clock one bit ahead of the slot and drives the overhead data bit during the slot.

Top module: `e1_sa_inserter`

## Requirements
- R1: After reset and before the first `frameStart`, `serOut` equals `serIn` and `linkReq` and `ohClk` stay low.
- R2: With source code 00 or 11, every bit of `serOut` equals `serIn` and neither strobe is raised, whatever the mask.
- R3: With source code 01, each enabled Sa slot of a non-alignment frame drives `serOut` from `linkData` and raises `linkReq` in that same cycle. `linkReq` is low on every other cycle.
- R4: With source code 10, `ohClk` is high for one cycle, exactly one bit before each enabled Sa slot, and `serOut` equals `ohData` during that slot.
- R5: Mask bit i (0 to 4) enables Sa(4+i), which is frame bit 3+i, counted from 0 at the `frameStart` cycle. Mask bit 0 is Sa4 and mask bit 4 is Sa8.
- R6: With an all-zero mask, no bit is replaced and no strobe is raised, for any source code.
- R7: A frame whose `nfasFrame` was low at its `frameStart` passes through untouched, with no strobes.
- R8: Sa positions that are not enabled, and all bits outside the Sa slots, take their value from `serIn`.
- R9: `srcSel`, `saEnable` and `nfasFrame` are sampled only on the `frameStart` cycle. Changes at other times first act in the next frame.
- R10: In an overhead-sourced non-alignment frame, the number of `ohClk` pulses equals the number of set mask bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | High on bit 0 of each frame |
| nfasFrame | input | 1 | Frame is a non-alignment frame (sampled with frameStart) |
| srcSel | input | 2 | Data link source: 00/11 serial, 01 link controller, 10 overhead port |
| saEnable | input | 5 | Carrier mask, bit i selects Sa(4+i) |
| serIn | input | 1 | Transmit serial stream in |
| linkData | input | 1 | Data bit from the link controller |
| ohData | input | 1 | Data bit from the overhead port |
| serOut | output | 1 | Transmit serial stream out |
| linkReq | output | 1 | Link controller bit request, high in the slot |
| ohClk | output | 1 | Overhead clock, high one bit before the slot |

## Verification
On every cycle, the assertions check the relations between the strobes and the data path. A link request means the output carries the link bit, and an overhead pulse means the next bit carries the overhead bit. The two strobes never coincide and are never raised on a frame's first bit, and every unstrobed bit equals the serial input. Only the bench scenarios can show that the strobes land on the right bit positions for a given mask. The scenarios also cover the pulse count per frame, the silence of alignment frames and of the serial source codes, and the deferral of a mid-frame configuration change to the next frame.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

  typedef enum logic [1:0] {
    SRC_SER_A = 2'b00,
    SRC_LINK  = 2'b01,
    SRC_OH    = 2'b10,
    SRC_SER_B = 2'b11
  } srcCode_e;

  typedef struct packed {
    logic takeLink;
    logic takeOh;
  } slotStrobe_t;

endpackage

// File: rtl/e1sa_ctrl.sv
module e1sa_ctrl
  import e1sa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SA_COUNT   = 5,
  parameter int SA_FIRST   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                nfasFrame,
  input  logic [1:0]          srcSel,
  input  logic [SA_COUNT-1:0] saEnable,
  output slotStrobe_t         strobe,
  output logic                linkReq,
  output logic                ohClk
);

  localparam int POS_W = $clog2(FRAME_BITS);

  logic [POS_W-1:0]    posQ;
  logic [POS_W-1:0]    curPos;
  logic                nfasQ;
  srcCode_e            srcQ;
  logic [SA_COUNT-1:0] enQ;
  logic [SA_COUNT-1:0] slotHit;
  logic [SA_COUNT-1:0] preHit;

  // Position of the bit on the line in this cycle
  assign curPos = frameStart ? '0 : posQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
    end else if (curPos == POS_W'(FRAME_BITS - 1)) begin
      posQ <= '0;
    end else begin
      posQ <= curPos + 1'b1;
    end
  end

  // Configuration is captured only at the frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nfasQ <= 1'b0;
      srcQ  <= SRC_SER_A;
      enQ   <= '0;
    end else if (frameStart) begin
      nfasQ <= nfasFrame;
      srcQ  <= srcCode_e'(srcSel);
      enQ   <= saEnable;
    end
  end

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_slot
    assign slotHit[k] = nfasQ && enQ[k] && (curPos == POS_W'(SA_FIRST + k));
    assign preHit[k]  = nfasQ && enQ[k] && (curPos == POS_W'(SA_FIRST + k - 1));
  end

  always_comb begin
    strobe.takeLink = (|slotHit) && (srcQ == SRC_LINK);
    strobe.takeOh   = (|slotHit) && (srcQ == SRC_OH);
    linkReq         = strobe.takeLink;
    ohClk           = (|preHit) && (srcQ == SRC_OH);
  end

endmodule

// File: rtl/e1sa_datapath.sv
module e1sa_datapath
  import e1sa_pkg::*;
(
  input  slotStrobe_t strobe,
  input  logic        serIn,
  input  logic        linkData,
  input  logic        ohData,
  output logic        serOut
);

  always_comb begin
    if (strobe.takeLink) begin
      serOut = linkData;
    end else if (strobe.takeOh) begin
      serOut = ohData;
    end else begin
      serOut = serIn;
    end
  end

endmodule

// File: rtl/e1_sa_inserter.sv
module e1_sa_inserter
  import e1sa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SA_COUNT   = 5,
  parameter int SA_FIRST   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                nfasFrame,
  input  logic [1:0]          srcSel,
  input  logic [SA_COUNT-1:0] saEnable,
  input  logic                serIn,
  input  logic                linkData,
  input  logic                ohData,
  output logic                serOut,
  output logic                linkReq,
  output logic                ohClk
);

  slotStrobe_t strobe;

  e1sa_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .SA_COUNT  (SA_COUNT),
    .SA_FIRST  (SA_FIRST)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .nfasFrame (nfasFrame),
    .srcSel    (srcSel),
    .saEnable  (saEnable),
    .strobe    (strobe),
    .linkReq   (linkReq),
    .ohClk     (ohClk)
  );

  e1sa_datapath u_dp (
    .strobe  (strobe),
    .serIn   (serIn),
    .linkData(linkData),
    .ohData  (ohData),
    .serOut  (serOut)
  );

endmodule

// File: rtl/e1_sa_inserter_chk.sv
module e1_sa_inserter_chk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic serIn,
  input logic linkData,
  input logic ohData,
  input logic serOut,
  input logic linkReq,
  input logic ohClk
);

  AST_LINK_BIT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |-> (serOut == linkData)); // R3

  AST_OH_BIT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (ohClk && !frameStart) |=> (frameStart || serOut == ohData)); // R4

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({linkReq, ohClk})); // R3

  AST_NO_STROBE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!linkReq && !ohClk)); // R5

  AST_PASS_UNSTROBED: assert property (@(posedge clk) disable iff (!rstN)
    (!linkReq && !($past(ohClk) && !frameStart)) |-> (serOut == serIn)); // R8

endmodule

bind e1_sa_inserter e1_sa_inserter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameStart(frameStart),
  .serIn     (serIn),
  .linkData  (linkData),
  .ohData    (ohData),
  .serOut    (serOut),
  .linkReq   (linkReq),
  .ohClk     (ohClk)
);

// File: tb/e1_sa_inserter_test.sv
`timescale 1ns/1ps
module e1_sa_inserter_test;

  localparam int FRAME_BITS = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       nfasFrame = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic [4:0] saEnable = '0;
  logic       serIn = 1'b0;
  logic       linkData = 1'b0;
  logic       ohData = 1'b0;
  logic       serOut;
  logic       linkReq;
  logic       ohClk;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  e1_sa_inserter uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .nfasFrame(nfasFrame),
    .srcSel(srcSel), .saEnable(saEnable), .serIn(serIn), .linkData(linkData),
    .ohData(ohData), .serOut(serOut), .linkReq(linkReq), .ohClk(ohClk)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One frame. Configuration a* is applied at frameStart, b* is driven from bit 1 on.
  task automatic runFrame(input string req, input logic nfas, input logic [1:0] srcA,
                          input logic [4:0] enA, input logic [1:0] srcB, input logic [4:0] enB);
    int serBad = 0;
    int linkBad = 0;
    int ohBad = 0;
    int ohCount = 0;
    int expCount = 0;
    for (int p = 0; p < FRAME_BITS; p++) begin
      logic act, expLink, expOh, expSer;
      int k;
      @(posedge clk);
      #1;
      frameStart = (p == 0);
      nfasFrame  = (p == 0) ? nfas : ~nfas;
      srcSel     = (p == 0) ? srcA : srcB;
      saEnable   = (p == 0) ? enA : enB;
      serIn      = 1'($urandom);
      linkData   = 1'($urandom);
      ohData     = 1'($urandom);
      k = p - 3;
      act = nfas && (k >= 0) && (k < 5) && enA[k[2:0]] && (srcA == 2'b01 || srcA == 2'b10);
      expLink = act && (srcA == 2'b01);
      expSer = act ? ((srcA == 2'b01) ? linkData : ohData) : serIn;
      expOh = nfas && (srcA == 2'b10) && (k + 1 >= 0) && (k + 1 < 5) && enA[3'(k + 1)];
      if (expOh) expCount++;
      @(negedge clk);
      if (serOut !== expSer) serBad++;
      if (linkReq !== expLink) linkBad++;
      if (ohClk !== expOh) ohBad++;
      if (ohClk === 1'b1) ohCount++;
    end
    check(req, "serOut mismatching bits", serBad, 0);
    check(req, "linkReq mismatching cycles", linkBad, 0);
    check(req, "ohClk mismatching cycles", ohBad, 0);
    check(req, "ohClk pulses in frame", ohCount, expCount);
  endtask

  task automatic testReset();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      #1;
      serIn = 1'($urandom);
      nfasFrame = 1'b1; srcSel = 2'b01; saEnable = 5'h1f;
      @(negedge clk);
      if (serOut !== serIn || linkReq !== 1'b0 || ohClk !== 1'b0) bad++;
    end
    check("R1", "bad cycles before first frame", bad, 0);
  endtask

  task automatic testSerialCodes();
    runFrame("R2", 1'b1, 2'b00, 5'h1f, 2'b00, 5'h1f);
    runFrame("R2", 1'b1, 2'b11, 5'h1f, 2'b11, 5'h1f);
  endtask

  task automatic testLinkSource();
    runFrame("R3", 1'b1, 2'b01, 5'h1f, 2'b01, 5'h1f);
    runFrame("R5_R8", 1'b1, 2'b01, 5'b10101, 2'b01, 5'b10101);
  endtask

  task automatic testOverheadSource();
    runFrame("R4", 1'b1, 2'b10, 5'h1f, 2'b10, 5'h1f);
    runFrame("R10", 1'b1, 2'b10, 5'b00010, 2'b10, 5'b00010);
    runFrame("R5", 1'b1, 2'b10, 5'b10000, 2'b10, 5'b10000);
  endtask

  task automatic testInactive();
    runFrame("R6", 1'b1, 2'b10, 5'h00, 2'b10, 5'h00);
    runFrame("R6", 1'b1, 2'b01, 5'h00, 2'b01, 5'h00);
  endtask

  task automatic testAlignFrame();
    runFrame("R7", 1'b0, 2'b01, 5'h1f, 2'b01, 5'h1f);
    runFrame("R7", 1'b0, 2'b10, 5'h1f, 2'b10, 5'h1f);
  endtask

  task automatic testMidFrameChange();
    runFrame("R9", 1'b1, 2'b01, 5'b11000, 2'b10, 5'b00011);
    runFrame("R9", 1'b1, 2'b10, 5'b00011, 2'b10, 5'b00011);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSerialCodes();
    testLinkSource();
    testOverheadSource();
    testInactive();
    testAlignFrame();
    testMidFrameChange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule